// File: doc/BRIEF.md
# Four-Value Sorting Pipeline

This block accepts a set of four unsigned values qualified by a valid bit and, a fixed number of cycles later, presents the same four values rearranged into sorted order together with a matching valid bit. It is meant to sit in a streaming datapath where a new set may arrive on any cycle and the consumer can always take a result, so the interface has no ready or stall signal.

Two elaboration parameters shape the timing and width: the number of pipeline register stages and the bit width of each value. A third parameter picks the direction of the sort, either smallest-first or largest-first, without changing the structure of the datapath. Internally a five-comparator network in three layers does the sorting. The layers are spread over the register stages, and any stages beyond the third only delay the result. The valid bit runs alongside the data in a shift line of the same depth.

Top module: `quad_sorter_pipe`

## Requirements
- R1: The block takes four values of `ELEM_W` bits (default 8) and returns four. Values compare as unsigned numbers, so 255 sorts above 128 and 0. Lane i occupies bits [i*ELEM_W +: ELEM_W] of each data port.
- R2: A set presented with `in_valid` high in cycle N appears with `out_valid` high in cycle N+`DEPTH` (default `DEPTH` is 3). `out_valid` is exactly `in_valid` delayed by `DEPTH` cycles.
- R3: A new set may be accepted in every cycle. Sets given in consecutive cycles come out in consecutive cycles, in the same order.
- R4: With `ORDER` = `SORT_ASC` (encoding 0, the default), lane 0 holds the smallest value and lane 3 the largest. For example, lanes {4,3,2,1} give {1,2,3,4} and {9,6,7,1} give {1,6,7,9}.
- R5: With `ORDER` = `SORT_DESC` (encoding 1), lane 0 holds the largest value. For example, {9,6,7,1} gives {9,7,6,1} and {4,8,0,9} gives {9,8,4,0}.
- R6: The output is a permutation of the input set. Equal values are legal, and each one keeps its multiplicity in the output.
- R7: While `rst_n` is low (asynchronous, active low), `out_valid` and `out_data` are zero. After reset, `out_valid` stays low until `DEPTH` cycles after the first valid input.
- R8: Input data in a cycle with `in_valid` low has no effect. The corresponding output cycle has `out_valid` low, and `out_data` keeps the last valid result.
- R9: `DEPTH` may be any value from 1 upward. The latency of R2 follows it in every configuration, including a two-stage build.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | 4*ELEM_W | Four unsigned values, lane 0 in the low bits |
| out_valid | output | 1 | Qualifies `out_data` |
| out_data | output | 4*ELEM_W | Sorted values, lane 0 in the low bits |

## Verification
Each result is due exactly `DEPTH` cycles after its input cycle: 3 cycles for the ascending instance and 2 for the descending instance, which run side by side on the same stimulus. The reference model keeps one queue entry per cycle and each instance's queue is preloaded with `DEPTH` idle entries, so the entry removed in a given cycle is the one that the output must show in that cycle. Idle cycles predict a held output value. An asynchronous reset clears and refills the queue, so the expected zeros apply from the next sample onward. Both the valid bit and all four lanes are compared on the falling edge of every cycle, away from the edge where the registers update.

// File: rtl/qsort_pkg.sv
package qsort_pkg;

    typedef enum logic {
        SORT_ASC  = 1'b0,
        SORT_DESC = 1'b1
    } sort_dir_e;

    localparam int NUM_LANES  = 4;
    localparam int NUM_LAYERS = 3;

    // Index of the first comparator layer placed in a given stage.
    function automatic int layer_first(input int stage);
        return (stage < NUM_LAYERS) ? stage : NUM_LAYERS;
    endfunction

    // Number of comparator layers placed in a given stage for a pipeline depth.
    function automatic int layer_count(input int stage, input int depth);
        if (stage >= NUM_LAYERS) return 0;
        if (stage == depth - 1)  return NUM_LAYERS - stage;
        return 1;
    endfunction

endpackage

// File: rtl/qsort_cas.sv
module qsort_cas
    import qsort_pkg::*;
#(
    parameter int        ELEM_W = 8,
    parameter sort_dir_e ORDER  = SORT_ASC
) (
    input  logic [ELEM_W-1:0] a_in,
    input  logic [ELEM_W-1:0] b_in,
    output logic [ELEM_W-1:0] lo_lane,
    output logic [ELEM_W-1:0] hi_lane
);
    logic swap;

    always_comb begin
        if (ORDER == SORT_ASC) swap = (a_in > b_in);
        else                   swap = (a_in < b_in);
        lo_lane = swap ? b_in : a_in;
        hi_lane = swap ? a_in : b_in;
    end
endmodule

// File: rtl/qsort_layer.sv
module qsort_layer
    import qsort_pkg::*;
#(
    parameter int        ELEM_W = 8,
    parameter sort_dir_e ORDER  = SORT_ASC,
    parameter int        LAYER  = 0
) (
    input  logic [NUM_LANES-1:0][ELEM_W-1:0] d_in,
    output logic [NUM_LANES-1:0][ELEM_W-1:0] d_out
);
    generate
        if (LAYER == 0) begin : g_adjacent
            qsort_cas #(.ELEM_W(ELEM_W), .ORDER(ORDER)) u_c01 (
                .a_in(d_in[0]), .b_in(d_in[1]), .lo_lane(d_out[0]), .hi_lane(d_out[1]));
            qsort_cas #(.ELEM_W(ELEM_W), .ORDER(ORDER)) u_c23 (
                .a_in(d_in[2]), .b_in(d_in[3]), .lo_lane(d_out[2]), .hi_lane(d_out[3]));
        end else if (LAYER == 1) begin : g_cross
            qsort_cas #(.ELEM_W(ELEM_W), .ORDER(ORDER)) u_c02 (
                .a_in(d_in[0]), .b_in(d_in[2]), .lo_lane(d_out[0]), .hi_lane(d_out[2]));
            qsort_cas #(.ELEM_W(ELEM_W), .ORDER(ORDER)) u_c13 (
                .a_in(d_in[1]), .b_in(d_in[3]), .lo_lane(d_out[1]), .hi_lane(d_out[3]));
        end else begin : g_middle
            assign d_out[0] = d_in[0];
            assign d_out[3] = d_in[3];
            qsort_cas #(.ELEM_W(ELEM_W), .ORDER(ORDER)) u_c12 (
                .a_in(d_in[1]), .b_in(d_in[2]), .lo_lane(d_out[1]), .hi_lane(d_out[2]));
        end
    endgenerate
endmodule

// File: rtl/qsort_stage.sv
module qsort_stage
    import qsort_pkg::*;
#(
    parameter int        ELEM_W = 8,
    parameter sort_dir_e ORDER  = SORT_ASC,
    parameter int        FIRST  = 0,
    parameter int        COUNT  = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic [NUM_LANES-1:0][ELEM_W-1:0] d_in,
    output logic [NUM_LANES-1:0][ELEM_W-1:0] q
);
    localparam int SUM_W = ELEM_W + 2;

    logic [NUM_LANES-1:0][ELEM_W-1:0] chain [0:COUNT];

    assign chain[0] = d_in;

    generate
        for (genvar j = 0; j < COUNT; j++) begin : g_layer
            qsort_layer #(.ELEM_W(ELEM_W), .ORDER(ORDER), .LAYER(FIRST + j)) u_layer (
                .d_in (chain[j]),
                .d_out(chain[j+1])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= chain[COUNT];
    end

    // Lane sums for the permutation check.
    logic [SUM_W-1:0] sum_in, sum_q;
    always_comb begin
        sum_in = '0;
        sum_q  = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            sum_in = sum_in + SUM_W'(d_in[i]);
            sum_q  = sum_q  + SUM_W'(q[i]);
        end
    end

    // R6: a loaded set keeps the total of its lanes
    p_keep_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sum_q == $past(sum_in)));

    // R8: no load, no change
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/qsort_valid_line.sv
module qsort_valid_line #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vin,
    output logic [DEPTH-1:0] vtap
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vtap <= '0;
        end else begin
            vtap[0] <= vin;
            for (int k = 1; k < DEPTH; k++) vtap[k] <= vtap[k-1];
        end
    end

    // R7: after a reset cycle every stage's valid is clear
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (vtap == '0));
endmodule

// File: rtl/quad_sorter_pipe.sv
module quad_sorter_pipe
    import qsort_pkg::*;
#(
    parameter int        ELEM_W = 8,
    parameter int        DEPTH  = 3,
    parameter sort_dir_e ORDER  = SORT_ASC
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [4*ELEM_W-1:0]   in_data,
    output logic                  out_valid,
    output logic [4*ELEM_W-1:0]   out_data
);
    logic [DEPTH-1:0]                 vtap;
    logic [DEPTH-1:0]                 ld;
    logic [NUM_LANES-1:0][ELEM_W-1:0] sdata [0:DEPTH];

    assign sdata[0] = in_data;

    qsort_valid_line #(.DEPTH(DEPTH)) u_vline (
        .clk  (clk),
        .rst_n(rst_n),
        .vin  (in_valid),
        .vtap (vtap)
    );

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_stage
            if (k == 0) begin : g_ld_in
                assign ld[k] = in_valid;
            end else begin : g_ld_tap
                assign ld[k] = vtap[k-1];
            end
            qsort_stage #(
                .ELEM_W(ELEM_W),
                .ORDER (ORDER),
                .FIRST (layer_first(k)),
                .COUNT (layer_count(k, DEPTH))
            ) u_stage (
                .clk  (clk),
                .rst_n(rst_n),
                .load (ld[k]),
                .d_in (sdata[k]),
                .q    (sdata[k+1])
            );
        end
    endgenerate

    assign out_valid = vtap[DEPTH-1];
    assign out_data  = sdata[DEPTH];

    // R4 / R5: every valid result is ordered in the selected direction
    generate
        if (ORDER == SORT_ASC) begin : g_chk_asc
            p_ordered_r4: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (sdata[DEPTH][0] <= sdata[DEPTH][1] &&
                               sdata[DEPTH][1] <= sdata[DEPTH][2] &&
                               sdata[DEPTH][2] <= sdata[DEPTH][3]));
        end else begin : g_chk_desc
            p_ordered_r5: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (sdata[DEPTH][0] >= sdata[DEPTH][1] &&
                               sdata[DEPTH][1] >= sdata[DEPTH][2] &&
                               sdata[DEPTH][2] >= sdata[DEPTH][3]));
        end
    endgenerate
endmodule

// File: tb/test_quad_sorter_pipe.sv
module test_quad_sorter_pipe;
    localparam int W  = 8;
    localparam int DA = 3;   // ascending instance depth
    localparam int DD = 2;   // descending instance depth (R9 two-stage build)

    typedef logic [3:0][W-1:0] set_t;
    typedef struct {
        bit   v;
        set_t d;
    } ent_t;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic   rst_n    = 1'b0;
    logic   in_valid = 1'b0;
    set_t   in_data  = '0;
    logic   va, vd;
    logic [4*W-1:0] oa, od;

    quad_sorter_pipe #(.ELEM_W(W), .DEPTH(DA), .ORDER(qsort_pkg::SORT_ASC)) i_quad_sorter_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(va), .out_data(oa));

    quad_sorter_pipe #(.ELEM_W(W), .DEPTH(DD), .ORDER(qsort_pkg::SORT_DESC)) i_quad_sorter_pipe_desc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(vd), .out_data(od));

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R7 reset";
    ent_t  qa[$];
    ent_t  qd[$];
    set_t  last_a = '0;
    set_t  last_d = '0;

    function automatic set_t mk(input int a0, input int a1, input int a2, input int a3);
        set_t s;
        s[0] = W'(a0); s[1] = W'(a1); s[2] = W'(a2); s[3] = W'(a3);
        return s;
    endfunction

    function automatic set_t ref_sort(input set_t d, input bit desc);
        int   a [4];
        int   t;
        set_t r;
        for (int i = 0; i < 4; i++) a[i] = int'(d[i]);
        for (int p = 0; p < 3; p++)
            for (int i = 0; i < 3 - p; i++)
                if (desc ? (a[i] < a[i+1]) : (a[i] > a[i+1])) begin
                    t = a[i]; a[i] = a[i+1]; a[i+1] = t;
                end
        for (int i = 0; i < 4; i++) r[i] = W'(a[i]);
        return r;
    endfunction

    task automatic model_reset();
        ent_t idle;
        idle.v = 1'b0;
        idle.d = '0;
        qa.delete();
        qd.delete();
        for (int i = 0; i < DA; i++) qa.push_back(idle);
        for (int i = 0; i < DD; i++) qd.push_back(idle);
        last_a = '0;
        last_d = '0;
    endtask

    task automatic check_dut(input bit desc, input logic got_v, input set_t got_d,
                             ref ent_t q[$], ref set_t last);
        ent_t  e;
        set_t  exp_d;
        string who;
        string dtag;
        e   = q.pop_front();
        who = desc ? "desc" : "asc";
        if (e.v) begin
            exp_d = ref_sort(e.d, desc);
            last  = exp_d;
            dtag  = desc ? "R5" : "R4";
        end else begin
            exp_d = last;
            dtag  = "R8";
        end
        n_cmp++;
        if (got_v !== e.v) begin
            n_bad++;
            $display("FAIL R2 [%s] %s: out_valid=%0b expected %0b", cur_tag, who, got_v, e.v);
        end
        n_cmp++;
        if (got_d !== exp_d) begin
            n_bad++;
            $display("FAIL %s [%s] %s: out_data=%h expected %h", dtag, cur_tag, who, got_d, exp_d);
        end
    endtask

    // One cycle: check outputs due now, then drive the next inputs.
    task automatic tick(input bit run, input bit v, input set_t d);
        ent_t e;
        @(negedge clk);
        check_dut(1'b0, va, oa, qa, last_a);
        check_dut(1'b1, vd, od, qd, last_d);
        if (!run) begin
            rst_n    = 1'b0;
            in_valid = 1'b0;
            in_data  = d;
            model_reset();
        end else begin
            rst_n    = 1'b1;
            in_valid = v;
            in_data  = d;
            e.v = v;
            e.d = d;
            qa.push_back(e);
            qd.push_back(e);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: run still active after %0d cycles, expected completion", 100000);
        finish_run();
    end

    initial begin
        model_reset();
        // R7: outputs zero during reset
        cur_tag = "R7 reset";
        repeat (3) tick(1'b0, 1'b0, mk(11, 22, 33, 44));
        tick(1'b1, 1'b0, mk(1, 2, 3, 4));

        // R3 R4 R5: examples back to back
        cur_tag = "R3 R4 R5 examples";
        tick(1'b1, 1'b1, mk(4, 3, 2, 1));
        tick(1'b1, 1'b1, mk(9, 6, 7, 1));
        tick(1'b1, 1'b1, mk(4, 8, 0, 9));

        // R8: garbage while invalid must not reach the output
        cur_tag = "R8 idle data ignored";
        repeat (4) tick(1'b1, 1'b0, mk(200, 3, 99, 7));
        tick(1'b1, 1'b0, mk(0, 255, 0, 255));

        // R6: duplicates preserved
        cur_tag = "R6 duplicates";
        tick(1'b1, 1'b1, mk(5, 5, 2, 5));
        tick(1'b1, 1'b1, mk(7, 7, 7, 7));
        tick(1'b1, 1'b0, mk(1, 1, 1, 1));
        tick(1'b1, 1'b1, mk(0, 0, 255, 255));

        // R1: unsigned full-range compares
        cur_tag = "R1 full range";
        tick(1'b1, 1'b1, mk(255, 0, 128, 255));
        tick(1'b1, 1'b1, mk(128, 127, 129, 1));
        repeat (4) tick(1'b1, 1'b0, mk(3, 3, 3, 3));

        // R2 R9: mixed stream checking latency of both depths
        cur_tag = "R2 R9 stream";
        for (int i = 0; i < 300; i++)
            tick(1'b1, ($urandom % 3) != 0, set_t'($urandom));

        // R7: reset with the pipeline full
        cur_tag = "R7 reset in flight";
        tick(1'b1, 1'b1, mk(10, 40, 30, 20));
        tick(1'b1, 1'b1, mk(60, 50, 70, 80));
        tick(1'b0, 1'b0, mk(0, 0, 0, 0));
        tick(1'b0, 1'b0, mk(0, 0, 0, 0));
        repeat (5) tick(1'b1, 1'b0, mk(9, 9, 9, 9));
        tick(1'b1, 1'b1, mk(2, 1, 4, 3));
        repeat (5) tick(1'b1, 1'b0, mk(0, 0, 0, 0));

        finish_run();
    end
endmodule